// File: doc/BRIEF.md
# NAND Flash Operation Sequencer

This block carries out one whole NAND flash transaction once software has filled in a few registers. It starts with a command byte. Then it sends between zero and five address bytes, moves an optional run of data bytes to or from the flash, and can send a second command byte. It holds off for a programmable settling interval, then waits until the flash ready/busy line reports ready. Last, it raises completion flags that software clears by writing ones.

Software sets up the second command, the address words, the transfer length and the strobe timing first. A write of the command word with its start bit set then launches the operation. Write data arrives as a byte stream that the block pulls one byte at a time. Read data leaves as a byte stream with a valid strobe.

Register selects on `reg_sel`:
- 0: command word (launches the operation)
- 1: second command
- 2: low address word
- 3: high address word
- 4: transfer length
- 5: flag clear
- 6: strobe timing
- 7: settle count

Top module: `nand_seq`

## Requirements
- R1: After reset both chip enables and both strobes are high, CLE, ALE and the bus enable are low, and `busy`, `op_done` and `rd_done` are 0.
- R2: A command-word write (select 0) with bit 31 set starts an operation whose first bus cycle puts bits 7:0 on the bus with CLE=1 and ALE=0. With bit 31 clear nothing happens.
- R3: While busy, command-word bit 19 selects the chip enable: set drives `nand_ce_n`=2'b01, clear drives 2'b10. When idle it is 2'b11.
- R4: Command-word bit 30 enables address cycles, and bits 29:27 hold the byte count minus one. Counts above five are clamped to five. Bytes go out with ALE=1, least significant first: select-2 bits 7:0 and 15:8, then select-3 bits 7:0, 15:8 and 23:16.
- R5: Address cycles depend only on that field and never on the opcode, so a status opcode 0x70 with a count of one emits exactly one address cycle.
- R6: With bit 25 set and bit 26 clear, the transfer-length (select 4) bytes are pulled from `wr_byte`, one `wr_take` pulse each, and sent with CLE=ALE=0 after the address cycles.
- R7: When second-command bit 8 is set, its bits 7:0 go out as one more CLE cycle after the address and write-data cycles.
- R8: After the last bus cycle the block idles for the settle count (select 7) plus about two cycles. It then stays waiting, with no read strobe and no completion, for as long as `nand_rb` is low.
- R9: With bit 26 set, once ready the block reads the transfer-length bytes with RE# pulses and presents each on `rd_byte` with `rd_vld`. It sets `rd_done` at the end. Bit 26 wins over bit 25.
- R10: `op_done` is set at the end of every operation. Writing select 5 with bit 31 set clears `op_done`, and bit 28 set clears `rd_done`. Zero bits have no effect.
- R11: Every strobe stays low for select-6 bits 7:0 cycles and high for bits 15:8 cycles before the next strobe. A zero count acts as one.
- R12: A command-word write while busy is ignored: it neither changes the running operation nor starts another afterward.
- R13: A transfer length of zero means no data phase in either direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select |
| reg_wdata | input | 32 | Register write data |
| wr_byte | input | 8 | Next write-data byte |
| wr_take | output | 1 | Write byte consumed |
| rd_byte | output | 8 | Captured read byte |
| rd_vld | output | 1 | Read byte valid |
| busy | output | 1 | Operation in progress |
| op_done | output | 1 | Operation-complete flag |
| rd_done | output | 1 | Read-transfer-complete flag |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_ce_n | output | 2 | Chip enables, active low |
| nand_dq_out | output | 8 | Bus value driven to flash |
| nand_dq_oe | output | 1 | Bus drive enable |
| nand_dq_in | input | 8 | Bus value from flash |
| nand_rb | input | 1 | Ready (1) / busy (0) |

## Verification
The hardest state to reach is the ready/busy wait, and hardest of all is a read that has to stay parked there. The stimulus holds `nand_rb` low before launching an operation that has address cycles, a second command and a read phase. It then idles for far longer than the bus cycles take, and checks that no read strobe and no completion appear. While parked, it also writes a new command word. After ready is released, it checks that the stray command never reached the bus. The settle interval is measured from the last write-strobe rise to the completion flag.

// File: rtl/nand_seq.sv
module nand_seq #(
  parameter int LEN_W = 12,
  parameter int TW = 8,
  parameter logic [TW-1:0] PW_RST = 2,
  parameter logic [TW-1:0] HOLD_RST = 2,
  parameter logic [TW-1:0] TWB_RST = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [2:0]       reg_sel,
  input  logic [31:0]      reg_wdata,
  input  logic [7:0]       wr_byte,
  output logic             wr_take,
  output logic [7:0]       rd_byte,
  output logic             rd_vld,
  output logic             busy,
  output logic             op_done,
  output logic             rd_done,
  output logic             nand_cle,
  output logic             nand_ale,
  output logic             nand_we_n,
  output logic             nand_re_n,
  output logic [1:0]       nand_ce_n,
  output logic [7:0]       nand_dq_out,
  output logic             nand_dq_oe,
  input  logic [7:0]       nand_dq_in,
  input  logic             nand_rb
);

  localparam logic [2:0] MAX_AIDX = 3'd4;

  typedef enum logic [3:0] {
    S_IDLE, S_CMD1, S_ADDR, S_WDAT, S_CMD2, S_TWB, S_WAIT, S_RDAT
  } st_t;

  st_t             st, nxt, tgt;
  logic            ph;
  logic [TW-1:0]   cnt;
  logic [LEN_W-1:0] idx, tgt_idx;
  logic [7:0]      dq_q;

  logic [8:0]      cmd2_q;
  logic [15:0]     alo_q;
  logic [31:0]     ahi_q;
  logic [LEN_W-1:0] len_q;
  logic [TW-1:0]   pw_q, hold_q, twb_q;

  logic            op_ce, op_aen, op_rd, op_wr;
  logic [2:0]      op_acnt;

  logic            strobe_st, step, adv, rpt, go, start, last_byte;
  logic [TW-1:0]   pw_eff, hold_eff;
  st_t             after_addr, after_wdat;
  logic [7:0]      abyte;

  assign pw_eff   = (pw_q == '0) ? TW'(1) : pw_q;
  assign hold_eff = (hold_q == '0) ? TW'(1) : hold_q;
  assign busy     = (st != S_IDLE);
  assign start    = reg_we && (reg_sel == 3'd0) && reg_wdata[31] && !busy;

  assign strobe_st = (st == S_CMD1) || (st == S_ADDR) || (st == S_WDAT) ||
                     (st == S_CMD2) || (st == S_RDAT);
  assign step      = strobe_st && ph && (cnt == '0);
  assign last_byte = (idx == len_q - 1'b1);

  assign after_wdat = cmd2_q[8] ? S_CMD2 : S_TWB;
  assign after_addr = (op_wr && !op_rd && len_q != '0) ? S_WDAT : after_wdat;

  always_comb begin
    case (tgt_idx[2:0])
      3'd0:    abyte = alo_q[7:0];
      3'd1:    abyte = alo_q[15:8];
      3'd2:    abyte = ahi_q[7:0];
      3'd3:    abyte = ahi_q[15:8];
      default: abyte = ahi_q[23:16];
    endcase
  end

  always_comb begin
    adv = 1'b0;
    rpt = 1'b0;
    nxt = st;
    case (st)
      S_IDLE: begin adv = start; nxt = S_CMD1; end
      S_CMD1: begin adv = step; nxt = op_aen ? S_ADDR : after_addr; end
      S_ADDR: begin
        adv = step && (idx[2:0] == op_acnt);
        rpt = step && !adv;
        nxt = after_addr;
      end
      S_WDAT: begin
        adv = step && last_byte;
        rpt = step && !adv;
        nxt = after_wdat;
      end
      S_CMD2: begin adv = step; nxt = S_TWB; end
      S_TWB:  begin adv = (cnt == '0); nxt = S_WAIT; end
      S_WAIT: begin
        adv = nand_rb;
        nxt = (op_rd && len_q != '0) ? S_RDAT : S_IDLE;
      end
      S_RDAT: begin
        adv = step && last_byte;
        rpt = step && !adv;
        nxt = S_IDLE;
      end
      default: begin adv = 1'b1; nxt = S_IDLE; end
    endcase
    go      = adv || rpt;
    tgt     = adv ? nxt : st;
    tgt_idx = adv ? '0 : idx + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd2_q <= '0;
      alo_q  <= '0;
      ahi_q  <= '0;
      len_q  <= '0;
      pw_q   <= PW_RST;
      hold_q <= HOLD_RST;
      twb_q  <= TWB_RST;
    end else if (reg_we) begin
      case (reg_sel)
        3'd1: cmd2_q <= reg_wdata[8:0];
        3'd2: alo_q  <= reg_wdata[15:0];
        3'd3: ahi_q  <= reg_wdata;
        3'd4: len_q  <= reg_wdata[LEN_W-1:0];
        3'd6: begin pw_q <= reg_wdata[TW-1:0]; hold_q <= reg_wdata[8 +: TW]; end
        3'd7: twb_q  <= reg_wdata[TW-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      ph      <= 1'b0;
      cnt     <= '0;
      idx     <= '0;
      dq_q    <= '0;
      op_ce   <= 1'b0;
      op_aen  <= 1'b0;
      op_rd   <= 1'b0;
      op_wr   <= 1'b0;
      op_acnt <= '0;
      wr_take <= 1'b0;
      rd_vld  <= 1'b0;
      rd_byte <= '0;
      op_done <= 1'b0;
      rd_done <= 1'b0;
    end else begin
      wr_take <= 1'b0;
      rd_vld  <= 1'b0;
      if (reg_we && reg_sel == 3'd5) begin
        if (reg_wdata[31]) op_done <= 1'b0;
        if (reg_wdata[28]) rd_done <= 1'b0;
      end
      if (start) begin
        op_ce   <= reg_wdata[19];
        op_aen  <= reg_wdata[30];
        op_rd   <= reg_wdata[26];
        op_wr   <= reg_wdata[25];
        op_acnt <= (reg_wdata[29:27] > MAX_AIDX) ? MAX_AIDX : reg_wdata[29:27];
      end
      if (strobe_st && !ph) begin
        if (cnt == '0) begin
          ph  <= 1'b1;
          cnt <= hold_eff - 1'b1;
          if (st == S_RDAT) begin
            rd_byte <= nand_dq_in;
            rd_vld  <= 1'b1;
          end
        end else begin
          cnt <= cnt - 1'b1;
        end
      end else if ((strobe_st || st == S_TWB) && cnt != '0) begin
        cnt <= cnt - 1'b1;
      end
      if (go) begin
        st  <= tgt;
        idx <= tgt_idx;
        ph  <= 1'b0;
        cnt <= pw_eff - 1'b1;
        case (tgt)
          S_CMD1: dq_q <= reg_wdata[7:0];
          S_CMD2: dq_q <= cmd2_q[7:0];
          S_ADDR: dq_q <= abyte;
          S_WDAT: begin dq_q <= wr_byte; wr_take <= 1'b1; end
          S_TWB:  cnt <= twb_q;
          S_IDLE: begin
            op_done <= 1'b1;
            if (op_rd) rd_done <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  assign nand_cle    = (st == S_CMD1) || (st == S_CMD2);
  assign nand_ale    = (st == S_ADDR);
  assign nand_dq_oe  = (st == S_CMD1) || (st == S_ADDR) || (st == S_WDAT) || (st == S_CMD2);
  assign nand_we_n   = !(nand_dq_oe && !ph);
  assign nand_re_n   = !((st == S_RDAT) && !ph);
  assign nand_dq_out = dq_q;
  assign nand_ce_n   = !busy ? 2'b11 : (op_ce ? 2'b01 : 2'b10);

  // R3
  ce_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> $countones(~nand_ce_n) == 1);

  // R3
  ce_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> nand_ce_n == 2'b11);

  // R8
  rb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WAIT && !nand_rb) |=> (st == S_WAIT && nand_re_n));

  // R9
  rd_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_vld |-> !$past(nand_re_n));

  // R6
  wr_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_take |-> (nand_dq_oe && !nand_cle && !nand_ale));

  // R10
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(op_done) |-> !busy);

  // R11
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!nand_we_n && !nand_re_n));

  // R12
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && reg_we && reg_sel == 3'd0) |=> $stable(op_ce) && $stable(op_rd));

endmodule

// File: tb/nand_seq_tb_top.sv
module nand_seq_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [2:0] reg_sel = '0;
  logic [31:0] reg_wdata = '0;
  logic [7:0] wr_byte;
  logic wr_take, rd_vld, busy, op_done, rd_done;
  logic [7:0] rd_byte;
  logic nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe;
  logic [1:0] nand_ce_n;
  logic [7:0] nand_dq_out;
  logic [7:0] nand_dq_in = '0;
  logic nand_rb = 1'b1;

  always #2.5 clk = ~clk;

  nand_seq dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .wr_byte(wr_byte), .wr_take(wr_take), .rd_byte(rd_byte), .rd_vld(rd_vld),
    .busy(busy), .op_done(op_done), .rd_done(rd_done),
    .nand_cle(nand_cle), .nand_ale(nand_ale), .nand_we_n(nand_we_n), .nand_re_n(nand_re_n),
    .nand_ce_n(nand_ce_n), .nand_dq_out(nand_dq_out), .nand_dq_oe(nand_dq_oe),
    .nand_dq_in(nand_dq_in), .nand_rb(nand_rb)
  );

  int checks = 0, failures = 0;
  bit finished = 0;
  logic [9:0] wlog [0:63];
  logic [7:0] rlog [0:63];
  int wn = 0, rn = 0, rcnt = 0, widx = 0, repulses = 0;
  int wmin = 999, wmax = 0, lowcnt = 0;
  logic prev_we = 1'b1;
  logic [1:0] ce_obs = 2'b11;
  bit ce_cap = 0;

  assign wr_byte = 8'h30 + 8'(widx);

  always @(posedge nand_we_n) if (rst_n && wn < 64) begin
    wlog[wn] = {nand_cle, nand_ale, nand_dq_out};
    wn++;
  end

  always @(negedge nand_re_n) if (rst_n) begin
    nand_dq_in <= 8'hA0 + 8'(rcnt);
    rcnt++;
    repulses++;
  end

  always @(negedge clk) begin
    if (wr_take) widx++;
    if (rd_vld && rn < 64) begin rlog[rn] = rd_byte; rn++; end
    if (busy && !ce_cap) begin ce_obs = nand_ce_n; ce_cap = 1; end
    if (!nand_we_n) lowcnt++;
    else if (!prev_we) begin
      if (lowcnt < wmin) wmin = lowcnt;
      if (lowcnt > wmax) wmax = lowcnt;
      lowcnt = 0;
    end
    prev_we = nand_we_n;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wreg(input logic [2:0] s, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = s; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic clear_logs();
    wn = 0; rn = 0; rcnt = 0; widx = 0; repulses = 0;
    wmin = 999; wmax = 0; lowcnt = 0; ce_cap = 0; ce_obs = 2'b11;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      if (!busy) break;
    end
  endtask

  task automatic t_reset();
    check(nand_ce_n == 2'b11 && nand_we_n && nand_re_n, "R1 pins", {nand_ce_n, nand_we_n, nand_re_n}, 4'hF);
    check(!nand_cle && !nand_ale && !nand_dq_oe, "R1 latches", {nand_cle, nand_ale, nand_dq_oe}, 0);
    check(!busy && !op_done && !rd_done, "R1 flags", {busy, op_done, rd_done}, 0);
  endtask

  task automatic t_nostart();
    clear_logs();
    wreg(3'd0, 32'h0000_0090);
    repeat (20) @(negedge clk);
    check(!busy && wn == 0, "R2 no start", wn, 0);
  endtask

  task automatic t_read_page();
    clear_logs();
    wreg(3'd6, 32'h0000_0302);
    wreg(3'd1, 32'h0000_0130);
    wreg(3'd2, 32'h0000_1234);
    wreg(3'd3, 32'h00AB_CDEF);
    wreg(3'd4, 32'd4);
    wreg(3'd0, 32'h8000_0000 | (1 << 30) | (4 << 27) | (1 << 26) | (1 << 19));
    wait_idle();
    check(wn == 7, "R4 cycle count", wn, 7);
    check(wlog[0] == 10'h200, "R2 first command", wlog[0], 10'h200);
    check(wlog[1] == 10'h134 && wlog[2] == 10'h112, "R4 low address bytes", {wlog[1], wlog[2]}, {10'h134, 10'h112});
    check(wlog[3] == 10'h1EF && wlog[4] == 10'h1CD && wlog[5] == 10'h1AB, "R4 high address bytes",
          wlog[5], 10'h1AB);
    check(wlog[6] == 10'h230, "R7 second command", wlog[6], 10'h230);
    check(ce_obs == 2'b01, "R3 chip one", ce_obs, 2'b01);
    check(rn == 4 && rlog[0] == 8'hA0 && rlog[3] == 8'hA3, "R9 read bytes", rn, 4);
    check(op_done && rd_done, "R9 flags", {op_done, rd_done}, 2'b11);
    check(wmin == 2 && wmax == 2, "R11 low width", wmax, 2);
  endtask

  task automatic t_flags();
    wreg(3'd5, 32'h0000_0000);
    check(op_done && rd_done, "R10 zero write", {op_done, rd_done}, 2'b11);
    wreg(3'd5, 32'h1000_0000);
    check(op_done && !rd_done, "R10 clear read flag", {op_done, rd_done}, 2'b10);
    wreg(3'd5, 32'h8000_0000);
    check(!op_done, "R10 clear done", op_done, 0);
  endtask

  task automatic t_program();
    clear_logs();
    wreg(3'd6, 32'h0000_0101);
    wreg(3'd1, 32'h0000_0110);
    wreg(3'd2, 32'h0000_0507);
    wreg(3'd4, 32'd3);
    wreg(3'd0, 32'h8000_0080 | (1 << 30) | (1 << 27) | (1 << 25));
    wait_idle();
    check(wn == 7, "R6 cycle count", wn, 7);
    check(wlog[0] == 10'h280 && wlog[1] == 10'h107 && wlog[2] == 10'h105, "R6 head", wlog[2], 10'h105);
    check(wlog[3] == 10'h030 && wlog[4] == 10'h031 && wlog[5] == 10'h032, "R6 data bytes", wlog[5], 10'h032);
    check(wlog[6] == 10'h210, "R7 confirm", wlog[6], 10'h210);
    check(widx == 3, "R6 take count", widx, 3);
    check(ce_obs == 2'b10, "R3 chip zero", ce_obs, 2'b10);
    check(op_done && !rd_done && rn == 0, "R10 write flags", {op_done, rd_done}, 2'b10);
    check(wmin == 1 && wmax == 1, "R11 width one", wmax, 1);
    wreg(3'd5, 32'h9000_0000);
  endtask

  task automatic t_status();
    clear_logs();
    wreg(3'd1, 32'h0);
    wreg(3'd2, 32'h0000_0000);
    wreg(3'd4, 32'd1);
    wreg(3'd0, 32'h8000_0070 | (1 << 30) | (1 << 26));
    wait_idle();
    check(wn == 2 && wlog[0] == 10'h270 && wlog[1] == 10'h100, "R5 status address", wn, 2);
    check(rn == 1 && rlog[0] == 8'hA0, "R9 status byte", rn, 1);
    wreg(3'd5, 32'h9000_0000);
  endtask

  task automatic t_wait();
    clear_logs();
    nand_rb = 1'b0;
    wreg(3'd1, 32'h0000_01D0);
    wreg(3'd4, 32'd2);
    wreg(3'd0, 32'h8000_0060 | (1 << 30) | (2 << 27) | (1 << 26));
    repeat (300) @(negedge clk);
    check(busy && !op_done && repulses == 0, "R8 held while busy", repulses, 0);
    wreg(3'd0, 32'h8000_0090);
    repeat (10) @(negedge clk);
    nand_rb = 1'b1;
    wait_idle();
    repeat (30) @(negedge clk);
    check(wn == 5 && wlog[4] == 10'h2D0, "R12 ignored command", wn, 5);
    check(!busy && rn == 2, "R12 no relaunch", rn, 2);
    wreg(3'd5, 32'h9000_0000);
  endtask

  task automatic t_twb();
    int n;
    clear_logs();
    wreg(3'd6, 32'h0000_0101);
    wreg(3'd7, 32'd20);
    wreg(3'd1, 32'h0);
    wreg(3'd4, 32'd0);
    wreg(3'd0, 32'h8000_00FF);
    for (int i = 0; i < 100 && nand_we_n; i++) @(negedge clk);
    for (int i = 0; i < 100 && !nand_we_n; i++) @(negedge clk);
    n = 0;
    while (!op_done && n < 200) begin @(negedge clk); n++; end
    check(n >= 22 && n <= 24, "R8 settle interval", n, 23);
    wreg(3'd5, 32'h9000_0000);
  endtask

  task automatic t_len0_clamp();
    clear_logs();
    wreg(3'd6, 32'h0000_0000);
    wreg(3'd7, 32'd1);
    wreg(3'd4, 32'd0);
    wreg(3'd0, 32'h8000_0000 | (1 << 30) | (7 << 27) | (1 << 26));
    wait_idle();
    check(wn == 6, "R4 clamp to five", wn, 6);
    check(rn == 0 && repulses == 0 && op_done && rd_done, "R13 zero length", rn, 0);
    check(wmin == 1 && wmax == 1, "R11 zero acts as one", wmax, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_nostart();
    t_read_page();
    t_flags();
    t_program();
    t_status();
    t_wait();
    t_twb();
    t_len0_clamp();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule